// File: doc/BRIEF.md
# EPP Host Controller

This block is the host end of an enhanced parallel port. A processor talks to it through eight byte-wide register offsets. Three offsets hold the classic parallel-port registers: the output data latch, the read-only status byte and the control latch. The other five start an enhanced-mode transfer: one address port and four data ports. Any access to one of those five runs an address or data cycle on the 8-bit peripheral bus. The cycle is strobed low and paced by the peripheral's ready/done handshake line.

Between enhanced cycles, the control latch owns the output pins and the bus direction, so standard and bidirectional operation keep working. Each enhanced cycle is guarded by a watchdog of about 10 microseconds. The watchdog length is derived from the clock frequency parameter. When it expires, the cycle is abandoned and a sticky timeout flag is raised. The register bus sees `reg_ready` low for the whole cycle and a one-cycle `reg_done` pulse when the access finishes or aborts.

Top module: `epp_host`

## Requirements
- R1: After reset the control latch, data latch and timeout flag are zero and `reg_ready` is high. The pins then show `pin_rst_n`=0, the three other strobe pins high and `pd_oe`=1.
- R2: Offset 0 writes the data latch. When idle with control bit 5 (DIR) clear, `pd_oe` is 1 and `pd_out` shows the latch. With DIR set, `pd_oe` is 0 and a read of offset 0 returns `pd_in` instead of the latch.
- R3: Offset 2 writes control bits 5:0 and reads them back, with bits 7:6 reading 0. When idle, `pin_stb_wr_n`=~bit0, `pin_afd_ds_n`=~bit1, `pin_sel_as_n`=~bit3 and always `pin_rst_n`=bit2.
- R4: A read of offset 1 returns {`per_rdy_n`, `per_ack`, `per_paper`, `per_online`, `per_fault_n`, 0, 0, timeout} from bit 7 down to bit 0.
- R5: `irq_out` equals `per_ack` AND control bit 4, and is 0 while bit 4 is clear.
- R6: An access to offset 3 (address) or offsets 4 to 7 (data) starts a cycle. During the cycle `pin_stb_wr_n` is low for writes and high for reads, and `pd_oe` equals the write flag. On writes `pd_out` carries the written byte. The strobe (`pin_sel_as_n` for offset 3, `pin_afd_ds_n` otherwise) goes low on the clock after `per_rdy_n` is sampled low, and rises on the clock after `per_rdy_n` is sampled high.
- R7: On an enhanced read, the byte on `pd_in` in the cycle where `per_rdy_n` is sampled high while strobing appears on `reg_rdata` when `reg_done` pulses.
- R8: `reg_ready` is low from the clock after an enhanced access is accepted until the cycle ends, and `reg_done` pulses for one cycle at the end of every access.
- R9: If a cycle has not completed after WD_CYCLES clocks of waiting or strobing (1000 with the defaults), it is aborted. The strobe is released, the timeout flag (status bit 0) is set and `reg_done` pulses. `reg_ready` is low for WD_CYCLES+1 clocks in total.
- R10: The timeout flag stays set until offset 1 is written with bit 0 = 1. Writing 0 there leaves it set.
- R11: After an enhanced cycle the pins and bus direction return to the control and data latches, and an enhanced write does not alter the data latch.
- R12: A request presented while `reg_ready` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_req | input | 1 | Access request, taken when reg_ready is high |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Write byte |
| reg_rdata | output | 8 | Read byte, valid with reg_done |
| reg_ready | output | 1 | High when a new access can be taken |
| reg_done | output | 1 | One-cycle pulse when an access ends |
| pd_in | input | 8 | Peripheral bus input |
| pd_out | output | 8 | Peripheral bus output |
| pd_oe | output | 1 | Peripheral bus drive enable |
| pin_stb_wr_n | output | 1 | Strobe when idle, write line during a cycle |
| pin_afd_ds_n | output | 1 | Autofeed when idle, data strobe during a cycle |
| pin_sel_as_n | output | 1 | Select-in when idle, address strobe during a cycle |
| pin_rst_n | output | 1 | Active-low peripheral initialise |
| per_rdy_n | input | 1 | Low = ready, high = transfer done (also busy status) |
| per_ack | input | 1 | Acknowledge / interrupt from peripheral |
| per_paper | input | 1 | Paper-end status |
| per_online | input | 1 | Selected status |
| per_fault_n | input | 1 | Error status |
| irq_out | output | 1 | Gated interrupt to the host |

## Verification
The assertions take for granted that `per_rdy_n` and the status inputs are synchronous to `clk` and need no synchroniser. They also take for granted that `reg_req` is a single-cycle pulse whose fields are stable for that cycle. The bench drives every input on the falling edge. Its peripheral responder changes `per_rdy_n` only in reaction to the strobe pins or in fixed stuck modes, so the handshake is never glitched inside a clock. Requests made during a busy cycle are deliberate and count as ignored by both the design and the reference model.

// File: rtl/epp_host_pkg.sv
package epp_host_pkg;

  typedef enum logic [1:0] {
    CY_IDLE     = 2'd0,
    CY_WAIT_RDY = 2'd1,
    CY_STROBE   = 2'd2,
    CY_RELEASE  = 2'd3
  } cyc_state_t;

  localparam logic [2:0] OFS_DATA  = 3'd0;
  localparam logic [2:0] OFS_STAT  = 3'd1;
  localparam logic [2:0] OFS_CTRL  = 3'd2;
  localparam logic [2:0] OFS_EADDR = 3'd3;

  // clocks that fit in limit_ns at clk_hz
  function automatic int unsigned wd_cycles(input int unsigned clk_hz,
                                            input int unsigned limit_ns);
    longint unsigned prod;
    prod = longint'(clk_hz) * longint'(limit_ns);
    return 32'(prod / 64'd1000000000);
  endfunction

  function automatic logic is_epp_port(input logic [2:0] ofs);
    return ofs >= OFS_EADDR;
  endfunction

endpackage

// File: rtl/epp_cycle_fsm.sv
module epp_cycle_fsm
  import epp_host_pkg::*;
#(
  parameter int unsigned WD_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       start_addr,
  input  logic       start_we,
  input  logic [7:0] start_byte,
  input  logic       per_rdy_n,
  output cyc_state_t state,
  output logic       is_addr,
  output logic       is_wr,
  output logic [7:0] wbyte,
  output logic       active,
  output logic       strobe_on,
  output logic       cap_evt,
  output logic       timeout_evt
);

  localparam int unsigned WDW = $clog2(WD_CYCLES + 1);

  logic [WDW-1:0] wd;
  logic           wd_zero;
  logic           done_seen;
  logic [WDW:0]   busy_len;

  assign wd_zero     = (wd == '0);
  assign done_seen   = (state == CY_STROBE) && per_rdy_n;
  assign active      = (state != CY_IDLE);
  assign strobe_on   = (state == CY_STROBE);
  assign cap_evt     = done_seen && !is_wr;
  assign timeout_evt = wd_zero && ((state == CY_WAIT_RDY) ||
                                   (state == CY_STROBE && !per_rdy_n));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= CY_IDLE;
      wd      <= '0;
      is_addr <= 1'b0;
      is_wr   <= 1'b0;
      wbyte   <= '0;
    end else begin
      unique case (state)
        CY_IDLE: begin
          if (start) begin
            state   <= CY_WAIT_RDY;
            wd      <= WDW'(WD_CYCLES - 1);
            is_addr <= start_addr;
            is_wr   <= start_we;
            wbyte   <= start_byte;
          end
        end
        CY_WAIT_RDY: begin
          if (wd_zero) begin
            state <= CY_RELEASE;
          end else begin
            wd <= wd - WDW'(1);
            if (!per_rdy_n) state <= CY_STROBE;
          end
        end
        CY_STROBE: begin
          if (per_rdy_n || wd_zero) state <= CY_RELEASE;
          else                      wd    <= wd - WDW'(1);
        end
        default: state <= CY_IDLE;
      endcase
    end
  end

  // cycles spent waiting or strobing, for the watchdog bound check
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                            busy_len <= '0;
    else if (state == CY_WAIT_RDY || state == CY_STROBE)   busy_len <= busy_len + 1'b1;
    else                                                   busy_len <= '0;
  end

  // R6
  strobe_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CY_STROBE && $past(state) == CY_WAIT_RDY) |-> !$past(per_rdy_n));

  // R9
  wd_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_len <= (WDW+1)'(WD_CYCLES));

  // R9
  abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> (state == CY_RELEASE));

endmodule

// File: rtl/epp_spp_regs.sv
module epp_spp_regs
  import epp_host_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_en,
  input  logic       acc_we,
  input  logic [2:0] acc_addr,
  input  logic [7:0] acc_wdata,
  input  logic [4:0] status_pins,
  input  logic [7:0] pd_in,
  input  logic       tmo_set,
  input  logic       cap_evt,
  output logic [5:0] ctl_q,
  output logic [7:0] data_q,
  output logic       tmo_q,
  output logic [7:0] rdata_q,
  output logic       spp_done
);

  logic [7:0] rd_mux;
  logic       wr_stat, wr_ctrl, wr_data;

  assign wr_data = acc_en && acc_we && (acc_addr == OFS_DATA);
  assign wr_stat = acc_en && acc_we && (acc_addr == OFS_STAT);
  assign wr_ctrl = acc_en && acc_we && (acc_addr == OFS_CTRL);

  always_comb begin
    unique case (acc_addr)
      OFS_DATA: rd_mux = ctl_q[5] ? pd_in : data_q;
      OFS_STAT: rd_mux = {status_pins, 2'b00, tmo_q};
      OFS_CTRL: rd_mux = {2'b00, ctl_q};
      default:  rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q    <= '0;
      data_q   <= '0;
      tmo_q    <= 1'b0;
      rdata_q  <= '0;
      spp_done <= 1'b0;
    end else begin
      spp_done <= acc_en;
      if (wr_data) data_q <= acc_wdata;
      if (wr_ctrl) ctl_q  <= acc_wdata[5:0];
      if (tmo_set)                     tmo_q <= 1'b1;
      else if (wr_stat && acc_wdata[0]) tmo_q <= 1'b0;
      if (acc_en && !acc_we) rdata_q <= rd_mux;
      else if (cap_evt)      rdata_q <= pd_in;
    end
  end

  // R10
  tmo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_q && !(wr_stat && acc_wdata[0])) |=> tmo_q);

  // R3
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(ctl_q));

endmodule

// File: rtl/epp_pin_mux.sv
module epp_pin_mux (
  input  logic       epp_active,
  input  logic       is_wr,
  input  logic       is_addr,
  input  logic       strobe_on,
  input  logic [7:0] wbyte,
  input  logic [7:0] data_q,
  input  logic       ctl_stb,
  input  logic       ctl_afd,
  input  logic       ctl_init,
  input  logic       ctl_sel,
  input  logic       ctl_dir,
  output logic [7:0] pd_out,
  output logic       pd_oe,
  output logic       stb_wr_n,
  output logic       afd_ds_n,
  output logic       sel_as_n,
  output logic       rst_pin_n
);

  always_comb begin
    if (epp_active) begin
      pd_oe    = is_wr;
      pd_out   = wbyte;
      stb_wr_n = !is_wr;
      afd_ds_n = !(strobe_on && !is_addr);
      sel_as_n = !(strobe_on && is_addr);
    end else begin
      pd_oe    = !ctl_dir;
      pd_out   = data_q;
      stb_wr_n = !ctl_stb;
      afd_ds_n = !ctl_afd;
      sel_as_n = !ctl_sel;
    end
    rst_pin_n = ctl_init;
  end

endmodule

// File: rtl/epp_host.sv
module epp_host
  import epp_host_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 100_000_000,
  parameter int unsigned LIMIT_NS = 10_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_req,
  input  logic       reg_we,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       reg_ready,
  output logic       reg_done,
  input  logic [7:0] pd_in,
  output logic [7:0] pd_out,
  output logic       pd_oe,
  output logic       pin_stb_wr_n,
  output logic       pin_afd_ds_n,
  output logic       pin_sel_as_n,
  output logic       pin_rst_n,
  input  logic       per_rdy_n,
  input  logic       per_ack,
  input  logic       per_paper,
  input  logic       per_online,
  input  logic       per_fault_n,
  output logic       irq_out
);

  localparam int unsigned WD_CYCLES = wd_cycles(CLK_HZ, LIMIT_NS);

  cyc_state_t state;
  logic       accept, epp_start, spp_acc;
  logic       is_addr, is_wr, epp_active, strobe_on, cap_evt, timeout_evt;
  logic [7:0] wbyte, data_q;
  logic [5:0] ctl_q;
  logic       tmo_q, spp_done;

  assign accept    = reg_req && reg_ready;
  assign epp_start = accept && is_epp_port(reg_addr);
  assign spp_acc   = accept && !is_epp_port(reg_addr);

  epp_cycle_fsm #(.WD_CYCLES(WD_CYCLES)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (epp_start),
    .start_addr  (reg_addr == OFS_EADDR),
    .start_we    (reg_we),
    .start_byte  (reg_wdata),
    .per_rdy_n   (per_rdy_n),
    .state       (state),
    .is_addr     (is_addr),
    .is_wr       (is_wr),
    .wbyte       (wbyte),
    .active      (epp_active),
    .strobe_on   (strobe_on),
    .cap_evt     (cap_evt),
    .timeout_evt (timeout_evt)
  );

  epp_spp_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_en      (spp_acc),
    .acc_we      (reg_we),
    .acc_addr    (reg_addr),
    .acc_wdata   (reg_wdata),
    .status_pins ({per_rdy_n, per_ack, per_paper, per_online, per_fault_n}),
    .pd_in       (pd_in),
    .tmo_set     (timeout_evt),
    .cap_evt     (cap_evt),
    .ctl_q       (ctl_q),
    .data_q      (data_q),
    .tmo_q       (tmo_q),
    .rdata_q     (reg_rdata),
    .spp_done    (spp_done)
  );

  epp_pin_mux u_mux (
    .epp_active (epp_active),
    .is_wr      (is_wr),
    .is_addr    (is_addr),
    .strobe_on  (strobe_on),
    .wbyte      (wbyte),
    .data_q     (data_q),
    .ctl_stb    (ctl_q[0]),
    .ctl_afd    (ctl_q[1]),
    .ctl_init   (ctl_q[2]),
    .ctl_sel    (ctl_q[3]),
    .ctl_dir    (ctl_q[5]),
    .pd_out     (pd_out),
    .pd_oe      (pd_oe),
    .stb_wr_n   (pin_stb_wr_n),
    .afd_ds_n   (pin_afd_ds_n),
    .sel_as_n   (pin_sel_as_n),
    .rst_pin_n  (pin_rst_n)
  );

  assign reg_ready = !epp_active;
  assign reg_done  = spp_done || (state == CY_RELEASE);
  assign irq_out   = per_ack && ctl_q[4];

  // R8
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    epp_start |=> !reg_ready);

  // R11
  idle_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !epp_active |-> (pd_oe == !ctl_q[5]));

  // R9
  tmo_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> tmo_q);

endmodule

// File: tb/epp_host_bench.sv
module epp_host_bench;

  localparam int WD = 1000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       reg_req = 1'b0, reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata, pd_out;
  logic       reg_ready, reg_done, pd_oe;
  logic [7:0] pd_in = '0;
  logic       pin_stb_wr_n, pin_afd_ds_n, pin_sel_as_n, pin_rst_n, irq_out;
  logic       per_rdy_n = 1'b0, per_ack = 1'b0, per_paper = 1'b0;
  logic       per_online = 1'b0, per_fault_n = 1'b1;

  epp_host u_epp_host (.*);

  int n_vec = 0, n_err = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int         m_phase, m_wd;
  bit         m_isaddr, m_iswr, m_sdone, m_tmo, m_lastrd;
  logic [7:0] m_wbyte, m_data, m_rdata;
  logic [5:0] m_ctl;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_wd = 0; m_isaddr = 0; m_iswr = 0; m_sdone = 0;
      m_tmo = 0; m_lastrd = 0; m_wbyte = 0; m_data = 0; m_rdata = 0; m_ctl = 0;
    end else begin
      m_sdone = 0;
      if (m_phase == 0) begin
        if (reg_req) begin
          m_lastrd = !reg_we;
          if (reg_addr >= 3) begin
            m_phase = 1; m_wd = WD - 1; m_isaddr = (reg_addr == 3);
            m_iswr = reg_we; m_wbyte = reg_wdata;
          end else begin
            m_sdone = 1;
            if (reg_we) begin
              if (reg_addr == 0) m_data = reg_wdata;
              if (reg_addr == 1 && reg_wdata[0]) m_tmo = 0;
              if (reg_addr == 2) m_ctl = reg_wdata[5:0];
            end else begin
              if (reg_addr == 0) m_rdata = m_ctl[5] ? pd_in : m_data;
              if (reg_addr == 1)
                m_rdata = {per_rdy_n, per_ack, per_paper, per_online, per_fault_n, 2'b00, m_tmo};
              if (reg_addr == 2) m_rdata = {2'b00, m_ctl};
            end
          end
        end
      end else if (m_phase == 1) begin
        if (m_wd == 0) begin m_tmo = 1; m_phase = 3; end
        else begin
          if (!per_rdy_n) m_phase = 2;
          m_wd--;
        end
      end else if (m_phase == 2) begin
        if (per_rdy_n) begin
          m_phase = 3;
          if (!m_iswr) m_rdata = pd_in;
        end else if (m_wd == 0) begin m_tmo = 1; m_phase = 3; end
        else m_wd--;
      end else begin
        m_phase = 0;
      end
    end
  end

  // compare on every clock, 3 ns after the rising edge
  bit cmp_on = 0;
  always begin
    @(posedge clk); #3;
    if (cmp_on && rst_n) begin
      chk(reg_ready == (m_phase == 0), "R8 ready", reg_ready, m_phase == 0);
      chk(reg_done == (m_sdone || m_phase == 3), "R8 done", reg_done, m_sdone || m_phase == 3);
      if (reg_done && m_lastrd)
        chk(reg_rdata == m_rdata, "R7 read byte", reg_rdata, m_rdata);
      if (m_phase != 0) begin
        chk(pd_oe == m_iswr, "R6 bus direction", pd_oe, m_iswr);
        if (m_iswr) chk(pd_out == m_wbyte, "R6 write byte", pd_out, m_wbyte);
        chk(pin_stb_wr_n == !m_iswr, "R6 write line", pin_stb_wr_n, !m_iswr);
        chk(pin_sel_as_n == !(m_phase == 2 && m_isaddr), "R6 address strobe",
            pin_sel_as_n, !(m_phase == 2 && m_isaddr));
        chk(pin_afd_ds_n == !(m_phase == 2 && !m_isaddr), "R6 data strobe",
            pin_afd_ds_n, !(m_phase == 2 && !m_isaddr));
      end else begin
        chk(pd_oe == !m_ctl[5], "R11 idle direction", pd_oe, !m_ctl[5]);
        if (pd_oe) chk(pd_out == m_data, "R2 data pins", pd_out, m_data);
        chk(pin_stb_wr_n == !m_ctl[0], "R3 strobe pin", pin_stb_wr_n, !m_ctl[0]);
        chk(pin_afd_ds_n == !m_ctl[1], "R3 autofeed pin", pin_afd_ds_n, !m_ctl[1]);
        chk(pin_sel_as_n == !m_ctl[3], "R3 select-in pin", pin_sel_as_n, !m_ctl[3]);
      end
      chk(pin_rst_n == m_ctl[2], "R3 init pin", pin_rst_n, m_ctl[2]);
      chk(irq_out == (m_ctl[4] & per_ack), "R5 irq", irq_out, m_ctl[4] & per_ack);
    end
  end

  // ---------------- peripheral responder ----------------
  int mode = 0;       // 0 normal, 1 stuck high, 2 stuck low
  int stall = 0, cnt = 0;
  always @(negedge clk) begin
    if (mode == 1)      per_rdy_n = 1'b1;
    else if (mode == 2) per_rdy_n = 1'b0;
    else if (stall > 0) begin per_rdy_n = 1'b1; stall--; end
    else if (!reg_ready && (!pin_sel_as_n || !pin_afd_ds_n)) begin
      if (cnt >= 2) per_rdy_n = 1'b1; else cnt++;
    end else begin
      cnt = 0; per_rdy_n = 1'b0;
    end
  end

  // ---------------- stimulus ----------------
  task automatic acc(input logic [2:0] a, input bit we, input logic [7:0] d,
                     output logic [7:0] q, output int busy);
    busy = 0;
    @(negedge clk); reg_req = 1; reg_we = we; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_req = 0;
    while (!reg_ready) begin busy++; @(negedge clk); end
    q = reg_rdata;
  endtask

  logic [7:0] q;
  int b;

  initial begin
    #(200000 * 10);
    n_err++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; cmp_on = 1;
    @(negedge clk);
    // R1 reset state
    chk(reg_ready == 1, "R1 ready", reg_ready, 1);
    chk(pin_rst_n == 0, "R1 init pin", pin_rst_n, 0);
    chk({pin_stb_wr_n, pin_afd_ds_n, pin_sel_as_n} == 3'b111, "R1 strobes",
        {pin_stb_wr_n, pin_afd_ds_n, pin_sel_as_n}, 7);
    chk(pd_oe == 1, "R1 direction", pd_oe, 1);
    acc(2, 0, 0, q, b); chk(q == 8'h00, "R1 control", q, 0);

    // R3 control latch
    acc(2, 1, 8'hC5, q, b);
    acc(2, 0, 0, q, b); chk(q == 8'h05, "R3 readback", q, 8'h05);
    chk(pin_stb_wr_n == 0 && pin_rst_n == 1, "R3 pins", {pin_stb_wr_n, pin_rst_n}, 1);

    // R2 data latch and reverse direction
    acc(0, 1, 8'hA5, q, b);
    acc(0, 0, 0, q, b); chk(q == 8'hA5, "R2 data read", q, 8'hA5);
    pd_in = 8'h3C;
    acc(2, 1, 8'h24, q, b);
    acc(0, 0, 0, q, b); chk(q == 8'h3C, "R2 reverse read", q, 8'h3C);
    chk(pd_oe == 0, "R2 reverse oe", pd_oe, 0);

    // R4 status
    per_ack = 1; per_paper = 1; per_online = 0; per_fault_n = 1;
    acc(1, 0, 0, q, b); chk(q == 8'h68, "R4 status", q, 8'h68);

    // R5 interrupt gating
    acc(2, 1, 8'h14, q, b); chk(irq_out == 1, "R5 enabled", irq_out, 1);
    acc(2, 1, 8'h04, q, b); chk(irq_out == 0, "R5 disabled", irq_out, 0);
    per_ack = 0;

    // R6 address write, R11 return to latches
    acc(3, 1, 8'h3C, q, b);
    chk(pd_oe == 1 && pd_out == 8'hA5, "R11 pins back", pd_out, 8'hA5);
    acc(0, 0, 0, q, b); chk(q == 8'hA5, "R11 latch kept", q, 8'hA5);

    // R6 data write with peripheral not ready at first
    stall = 4;
    acc(5, 1, 8'h5A, q, b); chk(b >= 6, "R6 stalled cycle", b, 6);

    // R7 reads
    pd_in = 8'h6E; acc(7, 0, 0, q, b); chk(q == 8'h6E, "R7 data read", q, 8'h6E);
    pd_in = 8'h91; acc(3, 0, 0, q, b); chk(q == 8'h91, "R7 address read", q, 8'h91);

    // R9 abort while waiting for ready
    mode = 1;
    acc(6, 1, 8'h11, q, b); chk(b == WD + 1, "R9 busy length", b, WD + 1);
    mode = 0;
    acc(1, 0, 0, q, b); chk(q[0] == 1, "R9 timeout flag", q[0], 1);

    // R10 sticky flag
    acc(1, 1, 8'h00, q, b);
    acc(1, 0, 0, q, b); chk(q[0] == 1, "R10 write 0 keeps", q[0], 1);
    acc(1, 1, 8'h01, q, b);
    acc(1, 0, 0, q, b); chk(q[0] == 0, "R10 write 1 clears", q[0], 0);

    // R9 abort while strobing
    mode = 2;
    acc(4, 0, 0, q, b); chk(b == WD + 1, "R9 strobe abort length", b, WD + 1);
    mode = 0;
    acc(1, 0, 0, q, b); chk(q[0] == 1, "R9 strobe abort flag", q[0], 1);
    acc(1, 1, 8'h01, q, b);

    // R12 request while busy is ignored
    mode = 1;
    @(negedge clk); reg_req = 1; reg_we = 1; reg_addr = 4; reg_wdata = 8'h22;
    @(negedge clk); reg_req = 0;
    repeat (5) @(negedge clk);
    reg_req = 1; reg_we = 1; reg_addr = 2; reg_wdata = 8'h3F;
    @(negedge clk); reg_req = 0;
    while (!reg_ready) @(negedge clk);
    mode = 0;
    acc(2, 0, 0, q, b); chk(q == 8'h04, "R12 control unchanged", q, 8'h04);
    acc(1, 1, 8'h01, q, b);

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

endmodule